// File: doc/BRIEF.md
# Persistent Fault Pulse Trip Detector

This block decides whether a residual-current sensor reports a steady, one-sided bias. Such a bias shows up as a train of short, active-low fault pulses, one in each excitation period. The first falling edge opens a qualification window. Every further falling edge inside the window adds one to a tally and restarts the window. When the tally reaches `TRIP_COUNT`, the block raises a trip.

If the train stops for longer than the window, the tally is dropped without a trip. This means a brief burst of noise can never build up to a trip over time.

All trip requests go to one output stretcher. That includes requests from a separate, already qualified trip input, for example a pulse-width path. The stretcher holds the trip output high for long enough to operate the disconnect actuator.

Top module: `persist_trip_detect`

## Requirements
- R1: While `rst_ni` is low, `trip_o` is low and the tally is zero. Asserting reset during a held trip drops `trip_o` immediately.
- R2: A fault pulse is a high-to-low transition of `fault_ni`, after two synchronizer flops. It adds exactly one to the tally, however many cycles `fault_ni` stays low.
- R3: Each counted edge (re)starts a window of `WIN_CYC` cycles. The next edge keeps the tally if it arrives at most `WIN_CYC` cycles after the previous one.
- R4: If no edge arrives within `WIN_CYC` cycles, the tally clears to zero. The next edge then counts as the first one.
- R5: The `TRIP_COUNT`-th edge of an unbroken train causes a trip. Call edge 1 the first clock edge that samples `fault_ni` low. `trip_o` is still low after edge 3 and is high after edge 4.
- R6: A train of `TRIP_COUNT`-1 edges followed by a gap longer than `WIN_CYC` produces no trip.
- R7: If `qual_trip_i` is high at a clock edge, `trip_o` is high after that edge.
- R8: After the last trip request, `trip_o` stays high for exactly `HOLD_CYC` cycles. A new request while it is high reloads the full hold time.
- R9: A trip clears the tally and closes the window. Another full `TRIP_COUNT` edges are then needed for the next pulse-count trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_ni | input | 1 | Asynchronous fault pulse from the comparator, active low |
| qual_trip_i | input | 1 | Synchronous trip request from another qualifier, active high |
| trip_o | output | 1 | Stretched trip to the disconnect actuator |

## Verification
The hardest situation to reach is a gap that lands exactly on the window edge. The design must accept an inter-edge spacing of exactly `WIN_CYC` cycles and reject a spacing of `WIN_CYC`+1. The stimulus places each falling edge of `fault_ni` on a chosen negative clock edge, so the spacing between synchronized edges is an exact cycle count.

Two further cases are easy to miss:
- A second trip right after a first one, which shows that the tally was cleared. The stimulus spaces the follow-on train so that the first stretch has ended before that train is complete.
- A re-trigger in the middle of a hold, which shows that the hold time is reloaded.

// File: rtl/persist_trip_pkg.sv
package persist_trip_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/fault_edge_sync.sv
module fault_edge_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_ni,
  output logic fall_o
);
  // chain[DEPTH-1] is the synchronized level, chain[DEPTH] its previous value
  logic [DEPTH:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[DEPTH-1:0], fault_ni};
  end

  assign fall_o = chain_q[DEPTH] & ~chain_q[DEPTH-1];

  assert_single_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/persist_window_ctr.sv
module persist_window_ctr #(
  parameter int unsigned TRIP_COUNT = 33,
  parameter int unsigned WIN_CYC    = 750
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  output logic trip_o
);
  localparam int unsigned CNT_W = persist_trip_pkg::cnt_width(TRIP_COUNT);
  localparam int unsigned WIN_W = persist_trip_pkg::cnt_width(WIN_CYC);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TRIP_COUNT - 1);
  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WIN_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [WIN_W-1:0] win_q;
  logic             trip_q;
  logic             hit;

  assign hit = fall_i && (cnt_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      win_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      trip_q <= hit;
      if (hit) begin
        cnt_q <= '0;
        win_q <= '0;
      end else if (fall_i) begin
        cnt_q <= cnt_q + 1'b1;
        win_q <= WIN_LOAD;
      end else if (win_q != '0) begin
        win_q <= win_q - 1'b1;
        if (win_q == WIN_W'(1)) cnt_q <= '0;  // window lapsed
      end
    end
  end

  assign trip_o = trip_q;

  assert_closed_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q == '0) |-> (cnt_q == '0));
  assert_count_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_CNT);
  assert_window_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !hit) |=> (win_q == WIN_LOAD));
  assert_trip_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_q |-> (cnt_q == '0 && win_q == '0));
endmodule

// File: rtl/trip_stretch.sv
module trip_stretch #(
  parameter int unsigned HOLD_CYC = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic qual_i,
  output logic trip_o
);
  localparam int unsigned HOLD_W = persist_trip_pkg::cnt_width(HOLD_CYC);

  logic [HOLD_W-1:0] hold_q;
  logic              any_req;

  assign any_req = req_i | qual_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hold_q <= '0;
    else if (any_req)         hold_q <= HOLD_W'(HOLD_CYC);
    else if (hold_q != '0)    hold_q <= hold_q - 1'b1;
  end

  assign trip_o = (hold_q != '0);

  assert_req_trips_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_req |=> trip_o);
  assert_no_early_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(trip_o) |-> !$past(any_req));
endmodule

// File: rtl/persist_trip_detect.sv
module persist_trip_detect #(
  parameter int unsigned TRIP_COUNT       = 33,
  parameter int unsigned DRIVE_PERIOD_CYC = 500,
  parameter int unsigned WIN_CYC          = DRIVE_PERIOD_CYC * 3 / 2,
  parameter int unsigned HOLD_CYC         = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_ni,
  input  logic qual_trip_i,
  output logic trip_o
);
  logic fall;
  logic cnt_trip;

  fault_edge_sync #(.DEPTH(persist_trip_pkg::SYNC_DEPTH)) i_sync (
    .clk_i, .rst_ni, .fault_ni, .fall_o(fall)
  );

  persist_window_ctr #(.TRIP_COUNT(TRIP_COUNT), .WIN_CYC(WIN_CYC)) i_win (
    .clk_i, .rst_ni, .fall_i(fall), .trip_o(cnt_trip)
  );

  trip_stretch #(.HOLD_CYC(HOLD_CYC)) i_stretch (
    .clk_i, .rst_ni, .req_i(cnt_trip), .qual_i(qual_trip_i), .trip_o
  );

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !trip_o);
endmodule

// File: tb/test_persist_trip_detect.sv
module test_persist_trip_detect;
  localparam int unsigned P_N    = 33;
  localparam int unsigned P_WIN  = 30;
  localparam int unsigned P_HOLD = 200;
  localparam int NV = 6;
  // {pulses, spacing, low cycles, expect trip}
  localparam int unsigned VEC [NV][4] = '{
    '{33, 20,  3, 1},   // R5 full train
    '{32, 20,  3, 0},   // R6 one short
    '{33, 30,  3, 1},   // R3 spacing at window limit
    '{33, 20, 15, 1},   // R2 long lows count once
    '{ 5, 20,  3, 0},   // R6 short burst
    '{33,  4,  1, 1}    // R5 dense train
  };
  localparam string TAG [NV] = '{"R5", "R6", "R3", "R2", "R6", "R5"};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fault_ni = 1'b1;
  logic qual_trip_i = 1'b0;
  logic trip_o;
  bit   seen = 1'b0;
  int   vectors = 0;
  int   fails = 0;

  always #2 clk = ~clk;

  persist_trip_detect #(
    .TRIP_COUNT(P_N), .DRIVE_PERIOD_CYC(20), .WIN_CYC(P_WIN), .HOLD_CYC(P_HOLD)
  ) i_persist_trip_detect (
    .clk_i(clk), .rst_ni, .fault_ni, .qual_trip_i, .trip_o
  );

  always @(negedge clk) if (trip_o) seen <= 1'b1;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; fault_ni = 1'b1; qual_trip_i = 1'b0;
    wait_n(3);
    seen = 1'b0;
    rst_ni = 1'b1;
    wait_n(2);
  endtask

  // falls spaced sp cycles apart; returns sp cycles after the last fall
  task automatic pulses(input int n, input int sp, input int lo);
    for (int i = 0; i < n; i++) begin
      fault_ni = 1'b0;
      wait_n(lo);
      fault_ni = 1'b1;
      wait_n(sp - lo);
    end
  endtask

  task automatic hold_len(output int n);
    n = 1;
    for (int i = 0; i < 10000 && trip_o; i++) begin
      @(negedge clk);
      if (trip_o) n++;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int n;
    // R1 reset state
    wait_n(2);
    chk("R1", trip_o, 0);
    do_reset();
    chk("R1", trip_o, 0);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      pulses(VEC[v][0], VEC[v][1], VEC[v][2]);
      wait_n(P_WIN + 8);
      chk(TAG[v], seen, VEC[v][3]);
    end

    // R5 exact latency, then R8 hold length
    do_reset();
    pulses(P_N - 1, 20, 3);
    chk("R6", trip_o, 0);
    fault_ni = 1'b0;
    wait_n(3);
    fault_ni = 1'b1;
    chk("R5", trip_o, 0);
    wait_n(1);
    chk("R5", trip_o, 1);
    hold_len(n);
    chk("R8", n, P_HOLD);

    // R7 qualifier input, R8 reload on retrigger
    qual_trip_i = 1'b1; wait_n(1); qual_trip_i = 1'b0;
    chk("R7", trip_o, 1);
    wait_n(99);
    chk("R8", trip_o, 1);
    qual_trip_i = 1'b1; wait_n(1); qual_trip_i = 1'b0;
    hold_len(n);
    chk("R8", n, P_HOLD);

    // R1 reset drops a held trip
    qual_trip_i = 1'b1; wait_n(1); qual_trip_i = 1'b0;
    wait_n(5);
    rst_ni = 1'b0;
    #1;
    chk("R1", trip_o, 0);
    wait_n(2);
    rst_ni = 1'b1;
    wait_n(2);

    // R4 gap of WIN+1 clears the tally
    do_reset();
    pulses(20, 20, 3);
    wait_n(P_WIN + 1 - 20);
    pulses(P_N - 1, 20, 3);
    wait_n(P_WIN + 8);
    chk("R4", seen, 0);

    // R3 gap of exactly WIN keeps the tally
    do_reset();
    pulses(20, 20, 3);
    wait_n(P_WIN - 20);
    pulses(P_N - 20, 20, 3);
    wait_n(8);
    chk("R3", seen, 1);

    // R9 tally restarts after a trip
    do_reset();
    pulses(P_N, 20, 3);
    pulses(P_N - 1, 20, 3);
    chk("R9", trip_o, 0);
    pulses(1, 20, 3);
    chk("R9", trip_o, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule